// File: doc/BRIEF.md
# Paging Address Translation Unit

This block turns 32-bit linear addresses into 32-bit physical addresses using 4 KB pages. A linear address is split into three fields. Bits 31:22 index a page directory, bits 21:12 index a page table, and bits 11:0 are the byte offset within the page, which passes through unchanged. A fully associative cache of 32 recent translations is searched first. On a hit, the physical address comes back in the cycle after the request is accepted.

On a miss, a two-level walker fetches a directory entry and then a table entry through a single-word memory read port. It installs the resulting frame in the cache and only then releases the translated address, by replaying the lookup so that it hits. In both kinds of entry, bit 0 is a present flag and bits 31:12 are a frame number. A non-present entry at either level ends the request with a fault and installs nothing. When paging is switched off, the linear address is returned as the physical address without any lookup. A flush input drops every cached translation in one cycle.

Requests use a valid/ready handshake, and only one request is in flight at a time. The response is a one-cycle pulse that carries either a physical address or a fault flag.

Top module: `paging_xlate_unit`

## Requirements
- R1: On a successful translation, `rsp_paddr[11:0]` equals the linear address bits 11:0 and `rsp_paddr[31:12]` equals bits 31:12 of the table entry that maps the page.
- R2: A request with paging enabled whose page is cached gives `rsp_valid` in the cycle after acceptance, with no memory read.
- R3: The directory entry is read from `{dir_base[31:12], laddr[31:22], 2'b00}`. The table entry is read from `{directory entry bits 31:12, laddr[21:12], 2'b00}`.
- R4: A miss is answered only after both entry reads and the cache install. A later request to the same page hits, with no memory read.
- R5: A directory entry with bit 0 clear ends the request after one read, with `rsp_fault`=1 and `rsp_paddr`=0.
- R6: A table entry with bit 0 clear ends the request after two reads, with `rsp_fault`=1 and `rsp_paddr`=0, and installs nothing. Repeating the request walks again.
- R7: With `paging_en`=0 at acceptance, the next cycle returns `rsp_paddr` equal to the linear address, with no fault and no memory read.
- R8: The cache holds 32 distinct pages at once. Empty entries are filled before any valid entry is replaced.
- R9: When all entries are valid, a fill replaces the least recently used entry. Both hits and fills count as uses.
- R10: A one-cycle `flush` pulse invalidates every entry, so the next request to any page walks again.
- R11: After reset, `req_ready`=1, `rsp_valid`=0, `mem_rd_valid`=0, and the cache is empty.
- R12: While a walk is in progress, `req_ready`=0. `mem_rd_valid` and `mem_rd_addr` stay stable until `mem_rsp_valid` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_en | input | 1 | Paging enable, sampled at acceptance |
| dir_base | input | 32 | Page directory base; bits 31:12 used |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | 32 | Linear address |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page fault indication |
| mem_rd_valid | output | 1 | Entry read request, held until answered |
| mem_rd_addr | output | 32 | Entry read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |

## Verification
The assertions assume that `mem_rsp_valid` pulses for one cycle only while `mem_rd_valid` is high, and that `dir_base` stays fixed while a walk runs. The bench's memory model answers each read exactly once, two cycles after it appears, and `dir_base` is never changed. The checks on the release point and the one-request-at-a-time rule rely on the requester waiting for each response. The driver does not issue a new request until the scoreboard has matched the previous one, and `flush` is pulsed only while the block is idle.

// File: rtl/paging_pkg.sv
package paging_pkg;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 12;
    localparam int LVL_W  = 10;
    localparam int PN_W   = ADDR_W - OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIR,
        ST_TBL,
        ST_REPLAY
    } walk_state_e;
endpackage

// File: rtl/xlate_lru.sv
module xlate_lru #(
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 touch_en,
    input  logic [$clog2(N)-1:0] touch_idx,
    input  logic [N-1:0]         valid,
    output logic [$clog2(N)-1:0] victim_idx
);
    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [N-1:0][IW-1:0] age;
    } lru_t;

    lru_t lru_d, lru_q;
    logic [N-1:0] oldest_vec;

    always_comb begin
        lru_d = lru_q;
        if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (lru_q.age[i] < lru_q.age[touch_idx]) begin
                    lru_d.age[i] = lru_q.age[i] + IW'(1);
                end
            end
            lru_d.age[touch_idx] = '0;
        end
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < N; i++) begin
            oldest_vec[i] = (lru_q.age[i] == IW'(N - 1));
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                victim_idx = IW'(i);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < N; i++) begin
                if (oldest_vec[i]) victim_idx = IW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) lru_q.age[i] <= IW'(i);
        end else begin
            lru_q <= lru_d;
        end
    end

    assert_one_oldest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(oldest_vec));
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
    parameter int N    = 32,
    parameter int PN_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [PN_W-1:0]      look_vpn,
    output logic                 hit,
    output logic [$clog2(N)-1:0] hit_idx,
    output logic [PN_W-1:0]      hit_pfn,
    input  logic                 fill_en,
    input  logic [$clog2(N)-1:0] fill_idx,
    input  logic [PN_W-1:0]      fill_vpn,
    input  logic [PN_W-1:0]      fill_pfn,
    output logic [N-1:0]         valid_o
);
    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [N-1:0]           valid;
        logic [N-1:0][PN_W-1:0] vpn;
        logic [N-1:0][PN_W-1:0] pfn;
    } tlb_t;

    tlb_t tlb_d, tlb_q;
    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = tlb_q.valid[g] && (tlb_q.vpn[g] == look_vpn);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        hit_pfn = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                hit_idx = IW'(i);
                hit_pfn = tlb_q.pfn[i];
            end
        end
    end

    always_comb begin
        tlb_d = tlb_q;
        if (flush) begin
            tlb_d.valid = '0;
        end else if (fill_en) begin
            tlb_d.valid[fill_idx] = 1'b1;
            tlb_d.vpn[fill_idx]   = fill_vpn;
            tlb_d.pfn[fill_idx]   = fill_pfn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tlb_q <= '0;
        else        tlb_q <= tlb_d;
    end

    assign valid_o = tlb_q.valid;

    assert_unique_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_o == '0));
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
    import paging_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 paging_en,
    input  logic [ADDR_W-1:0]    dir_base,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_laddr,
    output logic                 rsp_valid,
    output logic [ADDR_W-1:0]    rsp_paddr,
    output logic                 rsp_fault,
    output logic                 mem_rd_valid,
    output logic [ADDR_W-1:0]    mem_rd_addr,
    input  logic                 mem_rsp_valid,
    input  logic [ADDR_W-1:0]    mem_rsp_data,
    output logic [PN_W-1:0]      look_vpn,
    input  logic                 tlb_hit,
    input  logic [$clog2(N)-1:0] tlb_hit_idx,
    input  logic [PN_W-1:0]      tlb_hit_pfn,
    input  logic [$clog2(N)-1:0] victim_idx,
    output logic                 fill_en,
    output logic [$clog2(N)-1:0] fill_idx,
    output logic [PN_W-1:0]      fill_vpn,
    output logic [PN_W-1:0]      fill_pfn,
    output logic                 touch_en,
    output logic [$clog2(N)-1:0] touch_idx
);
    typedef struct packed {
        walk_state_e        state;
        logic [ADDR_W-1:0]  laddr;
        logic [PN_W-1:0]    pde_pfn;
        logic               rsp_valid;
        logic               rsp_fault;
        logic [ADDR_W-1:0]  rsp_paddr;
    } ctl_t;

    ctl_t c_d, c_q;
    logic unused_bits;
    assign unused_bits = ^{dir_base[OFF_W-1:0], mem_rsp_data[OFF_W-1:1]};

    always_comb begin
        c_d           = c_q;
        c_d.rsp_valid = 1'b0;
        c_d.rsp_fault = 1'b0;
        mem_rd_valid  = 1'b0;
        mem_rd_addr   = '0;
        fill_en       = 1'b0;
        fill_idx      = victim_idx;
        fill_vpn      = c_q.laddr[ADDR_W-1:OFF_W];
        fill_pfn      = mem_rsp_data[ADDR_W-1:OFF_W];
        touch_en      = 1'b0;
        touch_idx     = tlb_hit_idx;
        req_ready     = (c_q.state == ST_IDLE);
        look_vpn      = (c_q.state == ST_IDLE) ? req_laddr[ADDR_W-1:OFF_W]
                                               : c_q.laddr[ADDR_W-1:OFF_W];
        case (c_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.laddr = req_laddr;
                    if (!paging_en) begin
                        c_d.rsp_valid = 1'b1;
                        c_d.rsp_paddr = req_laddr;
                    end else if (tlb_hit) begin
                        c_d.rsp_valid = 1'b1;
                        c_d.rsp_paddr = {tlb_hit_pfn, req_laddr[OFF_W-1:0]};
                        touch_en      = 1'b1;
                    end else begin
                        c_d.state = ST_DIR;
                    end
                end
            end
            ST_DIR: begin
                mem_rd_valid = 1'b1;
                mem_rd_addr  = {dir_base[ADDR_W-1:OFF_W],
                                c_q.laddr[ADDR_W-1:ADDR_W-LVL_W], 2'b00};
                if (mem_rsp_valid) begin
                    if (mem_rsp_data[0]) begin
                        c_d.pde_pfn = mem_rsp_data[ADDR_W-1:OFF_W];
                        c_d.state   = ST_TBL;
                    end else begin
                        c_d.rsp_valid = 1'b1;
                        c_d.rsp_fault = 1'b1;
                        c_d.rsp_paddr = '0;
                        c_d.state     = ST_IDLE;
                    end
                end
            end
            ST_TBL: begin
                mem_rd_valid = 1'b1;
                mem_rd_addr  = {c_q.pde_pfn, c_q.laddr[OFF_W+LVL_W-1:OFF_W], 2'b00};
                if (mem_rsp_valid) begin
                    if (mem_rsp_data[0]) begin
                        fill_en   = 1'b1;
                        touch_en  = 1'b1;
                        touch_idx = victim_idx;
                        c_d.state = ST_REPLAY;
                    end else begin
                        c_d.rsp_valid = 1'b1;
                        c_d.rsp_fault = 1'b1;
                        c_d.rsp_paddr = '0;
                        c_d.state     = ST_IDLE;
                    end
                end
            end
            ST_REPLAY: begin
                if (tlb_hit) begin
                    c_d.rsp_valid = 1'b1;
                    c_d.rsp_paddr = {tlb_hit_pfn, c_q.laddr[OFF_W-1:0]};
                    touch_en      = 1'b1;
                    c_d.state     = ST_IDLE;
                end else begin
                    c_d.state = ST_DIR;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign rsp_valid = c_q.rsp_valid;
    assign rsp_fault = c_q.rsp_fault;
    assign rsp_paddr = c_q.rsp_paddr;

    assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !paging_en) |=>
            (rsp_valid && !rsp_fault && rsp_paddr == $past(req_laddr)));
    assert_hit_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && paging_en && tlb_hit) |=> (rsp_valid && !rsp_fault));
    assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
    assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == c_q.laddr[OFF_W-1:0]));
    assert_read_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rsp_valid) |=> (mem_rd_valid && $stable(mem_rd_addr)));
    assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);
endmodule

// File: rtl/paging_xlate_unit.sv
module paging_xlate_unit
    import paging_pkg::*;
#(
    parameter int TLB_ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paging_en,
    input  logic [31:0]       dir_base,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_laddr,
    output logic              rsp_valid,
    output logic [31:0]       rsp_paddr,
    output logic              rsp_fault,
    output logic              mem_rd_valid,
    output logic [31:0]       mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data
);
    localparam int IW = $clog2(TLB_ENTRIES);

    logic [PN_W-1:0]        look_vpn, hit_pfn, fill_vpn, fill_pfn;
    logic                   hit, fill_en, touch_en;
    logic [IW-1:0]          hit_idx, fill_idx, touch_idx, victim_idx;
    logic [TLB_ENTRIES-1:0] valid;

    xlate_ctrl #(.N(TLB_ENTRIES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .dir_base(dir_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .look_vpn(look_vpn), .tlb_hit(hit), .tlb_hit_idx(hit_idx),
        .tlb_hit_pfn(hit_pfn), .victim_idx(victim_idx),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .touch_en(touch_en), .touch_idx(touch_idx)
    );

    xlate_tlb #(.N(TLB_ENTRIES), .PN_W(PN_W)) u_tlb (
        .clk(clk), .rst_n(rst_n), .flush(flush), .look_vpn(look_vpn),
        .hit(hit), .hit_idx(hit_idx), .hit_pfn(hit_pfn),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .valid_o(valid)
    );

    xlate_lru #(.N(TLB_ENTRIES)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
        .valid(valid), .victim_idx(victim_idx)
    );
endmodule

// File: tb/paging_xlate_unit_bench.sv
module paging_xlate_unit_bench;
    localparam logic [31:0] DIR_BASE = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        paging_en = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_laddr = '0;
    logic        req_ready, rsp_valid, rsp_fault, mem_rd_valid;
    logic [31:0] rsp_paddr, mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #4 clk = ~clk;

    paging_xlate_unit u_paging_xlate_unit (
        .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .dir_base(DIR_BASE),
        .flush(flush), .req_valid(req_valid), .req_ready(req_ready),
        .req_laddr(req_laddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .mem_rd_valid(mem_rd_valid),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    typedef struct {
        logic [31:0] paddr;
        logic        fault;
        int          reads;
        bit          lat1;
        string       tag;
    } item_t;

    item_t sb[$];
    int tests = 0, fails = 0, cyc = 0, acc_cyc = 0, rd_cnt = 0, lat = 0;
    bit done = 1'b0;

    function automatic logic [19:0] frame_of(logic [9:0] d, logic [9:0] t);
        return {d, t} ^ 20'hA5A5A;
    endfunction

    function automatic logic [31:0] la(logic [9:0] d, logic [9:0] t, logic [11:0] off);
        return {d, t, off};
    endfunction

    function automatic logic [31:0] mem_model(logic [31:0] a);
        logic [9:0] d, t;
        if (a[31:12] == DIR_BASE[31:12]) begin
            d = a[11:2];
            if (d < 10'd8) return {12'h0, 8'h00 + {5'b0, 3'd0}, 12'h0} | {20'h00100 + {10'b0, d}, 12'h001};
            return 32'h0;
        end else if (a[31:15] == 17'h00020) begin
            d = {7'b0, a[14:12]};
            t = a[11:2];
            return {frame_of(d, t), 11'h0, (t != 10'h3FF)};
        end
        return 32'hFFFF_FFFE;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= 1'b0;
        if (mem_rd_valid && !mem_rsp_valid) begin
            if (lat == 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem_model(mem_rd_addr);
                lat <= 0;
            end else begin
                lat <= lat + 1;
            end
        end
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mem_rsp_valid) rd_cnt++;
        if (rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R12 unexpected response", rsp_paddr, 32'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(rsp_paddr == it.paddr, {it.tag, " paddr"}, rsp_paddr, it.paddr);
                check(rsp_fault == it.fault, {it.tag, " fault"}, {31'b0, rsp_fault}, {31'b0, it.fault});
                check(rd_cnt == it.reads, {it.tag, " reads"}, rd_cnt, it.reads);
                if (it.lat1) check(cyc - acc_cyc == 1, {it.tag, " latency"}, cyc - acc_cyc, 1);
            end
        end
    end

    task automatic issue(logic [31:0] a, logic pg, logic [31:0] ep, logic ef,
                         int er, bit l1, string tag);
        item_t it;
        it.paddr = ep; it.fault = ef; it.reads = er; it.lat1 = l1; it.tag = tag;
        @(negedge clk);
        paging_en = pg; req_laddr = a; req_valid = 1'b1; rd_cnt = 0;
        sb.push_back(it);
        while (!req_ready) @(negedge clk);
        acc_cyc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic miss(logic [9:0] d, logic [9:0] t, logic [11:0] o, string tag);
        issue(la(d, t, o), 1'b1, {frame_of(d, t), o}, 1'b0, 2, 1'b0, tag);
    endtask

    task automatic hitp(logic [9:0] d, logic [9:0] t, logic [11:0] o, string tag);
        issue(la(d, t, o), 1'b1, {frame_of(d, t), o}, 1'b0, 0, 1'b1, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 60000) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=<60000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R11 ready after reset", {31'b0, req_ready}, 32'h1);
        check(rsp_valid == 1'b0, "R11 no response after reset", {31'b0, rsp_valid}, 32'h0);
        check(mem_rd_valid == 1'b0, "R11 no read after reset", {31'b0, mem_rd_valid}, 32'h0);
        miss(10'd0, 10'd0, 12'h000, "R11 first access walks");

        issue(32'hDEAD_BEEF, 1'b0, 32'hDEAD_BEEF, 1'b0, 0, 1'b1, "R7 bypass");
        miss(10'd1, 10'd5, 12'h123, "R1 R3 walk translation");
        hitp(10'd1, 10'd5, 12'hFFF, "R2 R4 hit after install");
        issue(la(10'd9, 10'd1, 12'h010), 1'b1, 32'h0, 1'b1, 1, 1'b0, "R5 directory fault");
        issue(la(10'd2, 10'h3FF, 12'h044), 1'b1, 32'h0, 1'b1, 2, 1'b0, "R6 table fault");
        issue(la(10'd2, 10'h3FF, 12'h048), 1'b1, 32'h0, 1'b1, 2, 1'b0, "R6 table fault repeat");
        issue(la(10'd1, 10'd5, 12'h777), 1'b0, la(10'd1, 10'd5, 12'h777), 1'b0, 0, 1'b1, "R7 bypass cached page");

        pulse_flush();
        miss(10'd1, 10'd5, 12'h123, "R10 walk after flush");

        pulse_flush();
        for (int i = 0; i < 32; i++) miss(10'd3, 10'(i), 12'(i * 4), "R8 fill");
        for (int i = 0; i < 32; i++) hitp(10'd3, 10'(i), 12'h0AB, "R8 all resident");
        hitp(10'd3, 10'd0, 12'h001, "R9 touch oldest");
        miss(10'd4, 10'd40, 12'h002, "R9 fill evicts");
        hitp(10'd3, 10'd0, 12'h003, "R9 recent kept");
        miss(10'd3, 10'd1, 12'h004, "R9 lru evicted");
        hitp(10'd4, 10'd40, 12'h005, "R9 new entry kept");

        repeat (4) @(negedge clk);
        check(rsp_valid == 1'b0 && mem_rd_valid == 1'b0, "R12 idle quiet",
              {30'b0, rsp_valid, mem_rd_valid}, 32'h0);
        finish_run();
    end
endmodule